// File: doc/BRIEF.md
# Serial Flash Controller with Direct Pin Override

The block is a serial-peripheral master that sits behind a small 32-bit register port and a separate read-only memory window. It has two modes, chosen by one register bit. In memory-mapped mode, a read on the memory window runs a fast-read transaction on the first chip select. The transaction sends command 0x0B, a 24-bit address and one dummy byte, then clocks in four bytes, which answer the read. In direct mode, software sets the serial clock, data-out and every chip-select pin by writing a pin register. A hardware shift register records the data-in line at each rising clock that software makes, so software can read back what the device sent.

Software selects the mode with the mode register. In memory-mapped mode, the serial clock runs at the system clock divided by a factor taken from the control register. Pin-register writes made during memory-mapped mode are stored but do not reach the pins until direct mode is selected again.

Top module: `spif_ctrl`

## Requirements
- R1: After reset, the serial clock and data-out pins are low and all chip selects are high. The registers read: mode (offset 0x0) = 0, meaning memory-mapped; control (0x4) = 0x43; pin (0x8) = 0x0007_0000; capture (0xC) = 0.
- R2: Register reads are combinational. The mode register keeps only bit 0. The pin register keeps only bit 0 (data out), bit 8 (serial clock) and bits 16..18 (chip select n at bit 16+n, where 1 means high, that is, deselected). The control register keeps all 32 bits.
- R3: While mode bit 0 is 1 (direct mode), the pins show the stored pin-register bits from the cycle after the write.
- R4: A direct-mode pin-register write that takes bit 8 from 0 to 1 shifts the capture register left by one, with the data-in pin entering at bit 0. The register keeps the newest 32 bits. Other writes leave it unchanged. So do entering direct mode and a write that keeps bit 8 at 1.
- R5: In memory-mapped mode, pin-register writes leave the pins unchanged. The stored value appears on the pins once direct mode is selected.
- R6: A memory read in memory-mapped mode drives chip select 0 low and uses mode 0 framing: the clock idles low, bits go out MSB first, and data is set up while the clock is low. The frame is 0x0B, then the 24-bit address, then 8 zero bits, then 32 clock periods with data-out low. Chip selects 1 and 2 stay high.
- R7: Each serial-clock half period lasts N system cycles. N is control bits 7..0, sampled when the read starts, and a value of 0 acts as 1.
- R8: The read data is little-endian. The first received byte lands in bits 7..0 and the fourth in bits 31..24. Each byte arrives MSB first.
- R9: The ready pulse lasts one cycle and comes 144·N cycles after the cycle the read is accepted. Chip select 0 returns high in the same cycle, with the clock low.
- R10: A memory read in direct mode is answered one cycle after acceptance, with data 0 and no pin activity.
- R11: Writes to the capture register offset (0xC) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | input | 1 | Memory-window read request, held until ready |
| mem_addr | input | 24 | Flash byte address |
| mem_rdata | output | 32 | Memory-window read data |
| mem_ready | output | 1 | One-cycle read completion pulse |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_cs_n | output | 3 | Chip selects, active low |
| spi_miso | input | 1 | Serial data in |

## Verification
Results fall due at different points. Pin-register and mode writes show on the pins one edge after the write. Register reads are due in the same cycle. A direct-mode memory read gets ready one edge after acceptance, and a memory-mapped read gets ready exactly 144·N edges after acceptance. A behavioural model in the bench advances on every rising edge and predicts the clock, data-out, chip-select and ready levels. Those predictions are compared at each falling edge, half a cycle after the edge that changes them. The read tasks also count the edges from request to ready against 144·N+1. A flash model decodes the command frame and supplies the data bytes.

// File: rtl/spif_pkg.sv
`timescale 1ns/1ps
package spif_pkg;
   // register word index (byte offset >> 2)
   localparam logic [1:0] IDX_MODE = 2'd0;
   localparam logic [1:0] IDX_CTRL = 2'd1;
   localparam logic [1:0] IDX_PIN  = 2'd2;
   localparam logic [1:0] IDX_CAP  = 2'd3;

   // pin register field positions
   localparam int PIN_DO_BIT  = 0;
   localparam int PIN_CLK_BIT = 8;
   localparam int PIN_CS_LSB  = 16;

   localparam logic [7:0] FAST_READ_OP = 8'h0B;
   localparam int CAP_W = 32;

   typedef enum logic {ENG_IDLE, ENG_SHIFT} eng_state_t;
endpackage

// File: rtl/spif_regs.sv
`timescale 1ns/1ps
module spif_regs
   import spif_pkg::*;
#(
   parameter int          NUM_CS   = 3,
   parameter int          DIV_W    = 8,
   parameter logic [31:0] CTRL_RST = 32'h0000_0043
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [3:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   input  logic [CAP_W-1:0]  cap_q,
   output logic [31:0]       reg_rdata,
   output logic              direct_mode,
   output logic [DIV_W-1:0]  div_sel,
   output logic              pin_do,
   output logic              pin_clk,
   output logic [NUM_CS-1:0] pin_cs,
   output logic              clk_rise_wr
);
   logic [1:0]  idx;
   logic        unused_addr_lo;
   logic        mode_q;
   logic [31:0] ctrl_q;
   logic        do_q, clk_q;
   logic [NUM_CS-1:0] cs_q;

   assign idx            = reg_addr[3:2];
   assign unused_addr_lo = ^reg_addr[1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         ctrl_q <= CTRL_RST;
         do_q   <= 1'b0;
         clk_q  <= 1'b0;
         cs_q   <= '1;
      end else if (reg_we) begin
         case (idx)
            IDX_MODE: mode_q <= reg_wdata[0];
            IDX_CTRL: ctrl_q <= reg_wdata;
            IDX_PIN: begin
               do_q  <= reg_wdata[PIN_DO_BIT];
               clk_q <= reg_wdata[PIN_CLK_BIT];
               cs_q  <= reg_wdata[PIN_CS_LSB +: NUM_CS];
            end
            default: ;
         endcase
      end
   end

   assign clk_rise_wr = reg_we && (idx == IDX_PIN) && mode_q &&
                        reg_wdata[PIN_CLK_BIT] && !clk_q;

   always_comb begin
      reg_rdata = '0;
      case (idx)
         IDX_MODE: reg_rdata[0] = mode_q;
         IDX_CTRL: reg_rdata = ctrl_q;
         IDX_PIN: begin
            reg_rdata[PIN_DO_BIT]              = do_q;
            reg_rdata[PIN_CLK_BIT]             = clk_q;
            reg_rdata[PIN_CS_LSB +: NUM_CS]    = cs_q;
         end
         default:  reg_rdata = cap_q;
      endcase
   end

   assign direct_mode = mode_q;
   assign div_sel     = ctrl_q[DIV_W-1:0];
   assign pin_do      = do_q;
   assign pin_clk     = clk_q;
   assign pin_cs      = cs_q;
endmodule

// File: rtl/spif_capture.sv
`timescale 1ns/1ps
module spif_capture
   import spif_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             miso,
   output logic [CAP_W-1:0] cap_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)        cap_q <= '0;
      else if (shift_en) cap_q <= {cap_q[CAP_W-2:0], miso};
   end

   // R4
   cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(cap_q));
endmodule

// File: rtl/spif_fread.sv
`timescale 1ns/1ps
module spif_fread
   import spif_pkg::*;
#(
   parameter int DIV_W  = 8,
   parameter int ADDR_W = 24,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              direct_mode,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DIV_W-1:0]  div_sel,
   input  logic              miso,
   output logic              ready,
   output logic [DATA_W-1:0] rdata,
   output logic              sclk,
   output logic              mosi,
   output logic              cs_n
);
   localparam int OUT_BITS   = 8 + ADDR_W + 8;
   localparam int TOTAL_BITS = OUT_BITS + DATA_W;
   localparam int CNT_W      = $clog2(TOTAL_BITS);
   localparam int NBYTES     = DATA_W / 8;

   eng_state_t           state;
   logic [OUT_BITS-1:0]  tx_q;
   logic [DATA_W-1:0]    rx_q, rx_le;
   logic [CNT_W-1:0]     bit_cnt;
   logic [DIV_W-1:0]     div_cnt, half_q;

   // first received byte is the most significant in rx_q
   always_comb begin
      for (int j = 0; j < NBYTES; j++)
         rx_le[8*j +: 8] = rx_q[8*(NBYTES-1-j) +: 8];
   end

   assign mosi = tx_q[OUT_BITS-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ENG_IDLE;
         ready   <= 1'b0;
         rdata   <= '0;
         sclk    <= 1'b0;
         cs_n    <= 1'b1;
         tx_q    <= '0;
         rx_q    <= '0;
         bit_cnt <= '0;
         div_cnt <= '0;
         half_q  <= DIV_W'(1);
      end else begin
         ready <= 1'b0;
         case (state)
            ENG_IDLE: begin
               if (req && !ready) begin
                  if (direct_mode) begin
                     ready <= 1'b1;
                     rdata <= '0;
                  end else begin
                     state   <= ENG_SHIFT;
                     cs_n    <= 1'b0;
                     tx_q    <= {FAST_READ_OP, addr, 8'h00};
                     bit_cnt <= '0;
                     div_cnt <= '0;
                     half_q  <= (div_sel == '0) ? DIV_W'(1) : div_sel;
                  end
               end
            end
            default: begin
               if (div_cnt == half_q - DIV_W'(1)) begin
                  div_cnt <= '0;
                  if (!sclk) begin
                     sclk <= 1'b1;
                     rx_q <= {rx_q[DATA_W-2:0], miso};
                  end else begin
                     sclk <= 1'b0;
                     tx_q <= tx_q << 1;
                     if (bit_cnt == CNT_W'(TOTAL_BITS-1)) begin
                        state <= ENG_IDLE;
                        cs_n  <= 1'b1;
                        ready <= 1'b1;
                        rdata <= rx_le;
                     end else begin
                        bit_cnt <= bit_cnt + CNT_W'(1);
                     end
                  end
               end else begin
                  div_cnt <= div_cnt + DIV_W'(1);
               end
            end
         endcase
      end
   end

   // R9
   ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> !ready);
   // R9
   cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> ready);
   // R6
   clk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> !cs_n);
   // R10
   direct_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ENG_IDLE && req && !ready && direct_mode) |=> (ready && rdata == '0));
endmodule

// File: rtl/spif_ctrl.sv
`timescale 1ns/1ps
module spif_ctrl
   import spif_pkg::*;
#(
   parameter int          NUM_CS   = 3,
   parameter int          DIV_W    = 8,
   parameter int          ADDR_W   = 24,
   parameter logic [31:0] CTRL_RST = 32'h0000_0043
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [3:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              mem_req,
   input  logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_rdata,
   output logic              mem_ready,
   output logic              spi_sclk,
   output logic              spi_mosi,
   output logic [NUM_CS-1:0] spi_cs_n,
   input  logic              spi_miso
);
   if (NUM_CS < 1 || NUM_CS > 16) begin : g_bad_cs
      $error("NUM_CS must be 1..16");
   end
   if (DIV_W < 1 || DIV_W > 32) begin : g_bad_div
      $error("DIV_W must be 1..32");
   end
   if (ADDR_W < 8 || ADDR_W > 32 || (ADDR_W % 8) != 0) begin : g_bad_addr
      $error("ADDR_W must be a byte multiple in 8..32");
   end

   logic              direct_mode, pin_do, pin_clk, clk_rise_wr;
   logic [NUM_CS-1:0] pin_cs;
   logic [DIV_W-1:0]  div_sel;
   logic [CAP_W-1:0]  cap_q;
   logic              eng_sclk, eng_mosi, eng_cs_n;

   spif_regs #(.NUM_CS(NUM_CS), .DIV_W(DIV_W), .CTRL_RST(CTRL_RST)) u_regs (
      .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .cap_q, .reg_rdata,
      .direct_mode, .div_sel, .pin_do, .pin_clk, .pin_cs, .clk_rise_wr
   );

   spif_capture u_cap (
      .clk, .rst_n, .shift_en(clk_rise_wr), .miso(spi_miso), .cap_q
   );

   spif_fread #(.DIV_W(DIV_W), .ADDR_W(ADDR_W), .DATA_W(32)) u_eng (
      .clk, .rst_n, .req(mem_req), .direct_mode, .addr(mem_addr),
      .div_sel, .miso(spi_miso), .ready(mem_ready), .rdata(mem_rdata),
      .sclk(eng_sclk), .mosi(eng_mosi), .cs_n(eng_cs_n)
   );

   assign spi_sclk = direct_mode ? pin_clk : eng_sclk;
   assign spi_mosi = direct_mode ? pin_do  : eng_mosi;

   for (genvar n = 0; n < NUM_CS; n++) begin : g_cs
      if (n == 0) begin : g_flash
         assign spi_cs_n[n] = direct_mode ? pin_cs[n] : eng_cs_n;
      end else begin : g_other
         assign spi_cs_n[n] = direct_mode ? pin_cs[n] : 1'b1;
      end
   end

   if (NUM_CS > 1) begin : g_cs_chk
      // R6
      spare_cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !direct_mode |-> (&spi_cs_n[NUM_CS-1:1]));
   end
endmodule

// File: tb/spif_ctrl_tb.sv
`timescale 1ns/1ps
module spif_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req = 1'b0;
   logic [23:0] mem_addr = '0;
   logic [31:0] mem_rdata;
   logic        mem_ready;
   logic        spi_sclk, spi_mosi;
   logic [2:0]  spi_cs_n;
   logic        spi_miso;
   logic        tb_miso = 1'b0;
   logic        fl_miso = 1'b0;
   bit          flash_sel = 1'b1;

   int checks = 0, failures = 0, cyc = 0;
   bit done = 0, cmp_on = 0;

   always #2.5 clk = ~clk;
   assign spi_miso = flash_sel ? fl_miso : tb_miso;

   spif_ctrl u_dut (
      .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
      .mem_req, .mem_addr, .mem_rdata, .mem_ready,
      .spi_sclk, .spi_mosi, .spi_cs_n, .spi_miso
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] fbyte(input logic [23:0] a);
      logic [31:0] v;
      v = {8'h0, a} * 37 + 11;
      return v[7:0] ^ a[12:5];
   endfunction

   function automatic logic [31:0] le_word(input logic [23:0] a);
      return {fbyte(a + 24'd3), fbyte(a + 24'd2), fbyte(a + 24'd1), fbyte(a)};
   endfunction

   // ---------------- behavioural reference model ----------------
   bit          m_mode, m_busy, m_ready;
   logic [31:0] m_ctrl, m_pin, m_cap;
   int          m_k, m_n;
   logic [39:0] m_frame;

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_mode = 0; m_busy = 0; m_ready = 0;
         m_ctrl = 32'h43; m_pin = 32'h0007_0000; m_cap = 0;
         m_k = 0; m_n = 1; m_frame = '0;
      end else begin
         if (m_ready) m_ready = 0;
         else if (m_busy) begin
            m_k++;
            if (m_k == 144 * m_n) begin m_busy = 0; m_ready = 1; end
         end else if (mem_req) begin
            if (m_mode) m_ready = 1;
            else begin
               m_busy = 1; m_k = 0;
               m_n = (m_ctrl[7:0] == 0) ? 1 : int'(m_ctrl[7:0]);
               m_frame = {8'h0B, mem_addr, 8'h00};
            end
         end
         if (reg_we) begin
            case (reg_addr[3:2])
               2'd0: m_mode = reg_wdata[0];
               2'd1: m_ctrl = reg_wdata;
               2'd2: begin
                  if (m_mode && reg_wdata[8] && !m_pin[8]) m_cap = {m_cap[30:0], spi_miso};
                  m_pin = reg_wdata & 32'h0007_0101;
               end
               default: ;
            endcase
         end
      end
      if (cyc > 150000 && !done) begin
         done = 1;
         failures++;
         $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   // per-clock comparison, half a cycle after the updating edge
   always @(negedge clk) begin
      if (rst_n && cmp_on) begin
         logic es, em; logic [2:0] ec; int b;
         if (m_mode) begin
            es = m_pin[8]; em = m_pin[0]; ec = m_pin[18:16];
         end else if (m_busy) begin
            b  = m_k / (2 * m_n);
            es = (m_k % (2 * m_n)) >= m_n;
            ec = 3'b110;
            em = (b < 40) ? m_frame[39 - b] : 1'b0;
         end else begin
            es = 0; em = 0; ec = 3'b111;
         end
         chk({spi_sclk, spi_mosi, spi_cs_n, mem_ready} == {es, em, ec, m_ready},
             m_mode ? "R3 pins" : "R6/R7 pins",
             {spi_sclk, spi_mosi, spi_cs_n, mem_ready}, {es, em, ec, m_ready});
      end
   end

   // ---------------- flash device model ----------------
   int          fl_rise = 0;
   logic [39:0] fl_cmd = '0;
   logic        p_sclk = 0, p_cs = 1;
   always @(spi_sclk or spi_cs_n[0]) begin
      if (p_cs && !spi_cs_n[0]) fl_rise = 0;
      if (!spi_cs_n[0] && spi_sclk && !p_sclk) begin
         if (fl_rise < 40) fl_cmd[39 - fl_rise] = spi_mosi;
         fl_rise++;
      end
      if (!spi_cs_n[0] && !spi_sclk && p_sclk && fl_rise >= 40 && fl_rise < 72) begin
         int i; logic [7:0] bt;
         i  = fl_rise - 40;
         bt = fbyte(fl_cmd[31:8] + 24'(i / 8));
         fl_miso = bt[7 - (i % 8)];
      end
      p_sclk = spi_sclk; p_cs = spi_cs_n[0];
   end

   // ---------------- stimulus tasks ----------------
   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_we = 0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk); reg_addr = a; #0.5;
      chk(reg_rdata == exp, tag, reg_rdata, exp);
   endtask

   task automatic mem_rd(input logic [23:0] a, input logic [31:0] exp, input int exp_wait, input bit chk_cmd);
      int waited = 0;
      @(negedge clk); mem_req = 1; mem_addr = a;
      do begin @(negedge clk); waited++; end while (!mem_ready && waited < 20000);
      mem_req = 0;
      chk(mem_rdata == exp, "R8 rdata", mem_rdata, exp);
      chk(waited == exp_wait, "R9 latency", waited, exp_wait);
      if (chk_cmd) chk(fl_cmd == {8'h0B, a, 8'h00}, "R6 frame", fl_cmd, {8'h0B, a, 8'h00});
   endtask

   initial begin
      logic [31:0] exp_cap;
      logic [31:0] pat;
      repeat (3) @(negedge clk);
      chk({spi_sclk, spi_mosi, spi_cs_n} == 5'b00111, "R1 pins in reset", {spi_sclk, spi_mosi, spi_cs_n}, 5'b00111);
      rst_n = 1;
      cmp_on = 1;
      rd(4'h0, 32'h0, "R1 mode");
      rd(4'h4, 32'h43, "R1 ctrl");
      rd(4'h8, 32'h0007_0000, "R1 pin");
      rd(4'hC, 32'h0, "R1 cap");

      wr(4'hC, 32'hFFFF_FFFF);
      rd(4'hC, 32'h0, "R11 cap write ignored");
      wr(4'h0, 32'hFFFF_FFFE);
      rd(4'h0, 32'h0, "R2 mode mask");

      // R7 reset divider 0x43
      mem_rd(24'h000100, le_word(24'h000100), 144 * 67 + 1, 1);
      wr(4'h4, 32'h2);
      rd(4'h4, 32'h2, "R2 ctrl");
      mem_rd(24'h123456, le_word(24'h123456), 144 * 2 + 1, 1);
      wr(4'h4, 32'h0);
      mem_rd(24'hFFFFFE, le_word(24'hFFFFFE), 144 + 1, 1);   // R7 zero acts as one
      wr(4'h4, 32'h103);
      mem_rd(24'hABCDEF, le_word(24'hABCDEF), 144 * 3 + 1, 1); // R7 upper bits ignored

      // R5 pin writes held off in memory-mapped mode
      wr(4'h8, 32'hFFFF_FFFF);
      chk({spi_sclk, spi_mosi, spi_cs_n} == 5'b00111, "R5 pins unchanged", {spi_sclk, spi_mosi, spi_cs_n}, 5'b00111);
      rd(4'h8, 32'h0007_0101, "R2 pin mask");
      wr(4'h0, 32'h1);
      chk({spi_sclk, spi_mosi, spi_cs_n} == 5'b11111, "R5 applied on entry", {spi_sclk, spi_mosi, spi_cs_n}, 5'b11111);
      rd(4'hC, 32'h0, "R4 no capture on entry");

      // R3 / R4 direct bit-bang
      flash_sel = 0;
      wr(4'h8, 32'h0006_0001);
      chk({spi_sclk, spi_mosi, spi_cs_n} == 5'b01110, "R3 pins follow", {spi_sclk, spi_mosi, spi_cs_n}, 5'b01110);
      exp_cap = 0;
      pat = 32'hDEAD_BEEF;
      for (int i = 0; i < 36; i++) begin
         logic b;
         b = pat[(i * 7) % 32];
         tb_miso = b;
         wr(4'h8, {13'h0, 3'b110, 7'h0, 1'b0, 7'h0, b});
         wr(4'h8, {13'h0, 3'b110, 7'h0, 1'b1, 7'h0, b});
         exp_cap = {exp_cap[30:0], b};
         if (i == 7) begin
            tb_miso = ~b;
            wr(4'h8, 32'h0006_0100);   // clock stays high: no shift
            rd(4'hC, exp_cap, "R4 no shift on held clock");
         end
      end
      rd(4'hC, exp_cap, "R4 newest 32 bits");
      rd(4'hC, m_cap, "R4 model");
      wr(4'hC, 32'h0);
      rd(4'hC, exp_cap, "R11 cap write ignored direct");

      // R10 memory read in direct mode
      mem_rd(24'h000040, 32'h0, 1, 0);
      chk(spi_cs_n == 3'b110, "R10 pins untouched", spi_cs_n, 3'b110);

      // back to memory-mapped mode
      wr(4'h8, 32'h0007_0000);
      wr(4'h0, 32'h0);
      flash_sel = 1;
      chk({spi_sclk, spi_mosi, spi_cs_n} == 5'b00111, "R6 idle pins", {spi_sclk, spi_mosi, spi_cs_n}, 5'b00111);
      mem_rd(24'h00C0DE, le_word(24'h00C0DE), 144 * 3 + 1, 1);

      repeat (4) @(negedge clk);
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule